// File: doc/BRIEF.md
# Bus Cycle Command Strobe Generator

This block sits between a processor that announces each bus cycle with a 3-bit status code and the memory and I/O subsystem behind it. It watches the status lines. When they leave the idle code, it records the cycle type and then produces the strobes that the memory and I/O devices need for that cycle: an address latch pulse, the read, write and interrupt-acknowledge commands, a data-enable window and a data-direction level.

Writes get two strobes. An early write strobe starts together with the read-type commands. A normal write strobe follows a configurable number of clocks later, so that slow devices see settled data. Halt cycles are framed like any other cycle but raise no command and no data enable. A cycle ends when the status goes back to idle while the ready input is high. The command strobes can be built active-high or active-low.

Top module: `cyc_cmd_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, ale, den and every command are inactive and dt_r is high.
- R2: A cycle starts on a rising clock edge where the status sampled on the previous edge was the idle code 111, the current status is not 111, and no cycle is in progress. After that edge ale is high for exactly one clock, and no command and no den is active while ale is high.
- R3: Status codes are as follows: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write, 111 idle. The matching read, interrupt-acknowledge or early-write command turns on at the second edge of the cycle. At most one of these commands is active at a time.
- R4: Instruction fetch (100) and memory read (101) both drive mem_rd and no other command.
- R5: A halt cycle (011) drives no command and no den at any point of the cycle, although ale still pulses.
- R6: The normal write strobes mem_wr and io_wr turn on WRITE_LAG clocks after the matching early strobes mem_wr_adv and io_wr_adv. They stay on together with the early strobes until the cycle ends.
- R7: All commands and den turn off on the edge where the status is 111 and ready is high. While ready is low they stay on, even with status 111. A cycle that ends on its second edge raises no command.
- R8: dt_r is driven from the ale edge until the cycle ends. It is low for codes with status bit 1 equal to 0 (interrupt acknowledge, I/O read, fetch, memory read) and high for all other codes. It is high while idle.
- R9: The cycle type is captured at the start edge. A change of status to another non-idle code during a cycle produces no new ale and does not change the commands.
- R10: den turns on and off on the same edges as the commands of every cycle other than halt.
- R11: With CMD_ACTIVE_LOW=1 the seven command outputs are the complements of their active-high values. ale, den and dt_r are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_status | input | 3 | Bus-cycle status code from the processor |
| ready | input | 1 | High when the addressed device may finish the cycle |
| ale | output | 1 | Address latch enable pulse |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Data direction: 1 transmit, 0 receive |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command, normal timing |
| mem_wr_adv | output | 1 | Memory write command, early timing |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command, normal timing |
| io_wr_adv | output | 1 | I/O write command, early timing |
| int_ack | output | 1 | Interrupt acknowledge command |

## Verification
The bench builds two copies side by side with WRITE_LAG=2. One has active-high commands and the other active-low, so both polarity variants are checked on every sample. A lag of 2 puts a clock between the early and the normal write strobe, so the lag counter must both count and saturate. A lag of 1 would hide an off-by-one in that counter. Every one of the seven non-idle codes is swept through a full cycle that includes a ready-low stall, and further runs cover a cycle cut short on its second edge and a status change in the middle of a cycle.

// File: rtl/cyc_cmd_pkg.sv
package cyc_cmd_pkg;

   localparam int STAT_W = 3;
   localparam int NCMD   = 7;

   typedef enum logic [STAT_W-1:0] {
      ST_INTA  = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_IDLE  = 3'b111
   } bus_stat_e;

   typedef struct packed {
      logic mrd;
      logic mwr;
      logic iord;
      logic iowr;
      logic inta;
   } cmd_set_t;

   typedef struct packed {
      cmd_set_t cmd;
      logic     moves_data;
      logic     inbound;
   } cyc_class_t;

   function automatic cyc_class_t classify(input logic [STAT_W-1:0] code);
      cyc_class_t c;
      c = '0;
      case (bus_stat_e'(code))
         ST_INTA:  begin c.cmd.inta = 1'b1; c.moves_data = 1'b1; c.inbound = 1'b1; end
         ST_IORD:  begin c.cmd.iord = 1'b1; c.moves_data = 1'b1; c.inbound = 1'b1; end
         ST_IOWR:  begin c.cmd.iowr = 1'b1; c.moves_data = 1'b1; end
         ST_FETCH: begin c.cmd.mrd  = 1'b1; c.moves_data = 1'b1; c.inbound = 1'b1; end
         ST_MRD:   begin c.cmd.mrd  = 1'b1; c.moves_data = 1'b1; c.inbound = 1'b1; end
         ST_MWR:   begin c.cmd.mwr  = 1'b1; c.moves_data = 1'b1; end
         default:  c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/cyc_cmd_map.sv
module cyc_cmd_map
   import cyc_cmd_pkg::*;
(
   input  logic [STAT_W-1:0] code,
   output cyc_class_t        cls
);

   always_comb begin
      cls = classify(code);
   end

endmodule

// File: rtl/cyc_status_track.sv
module cyc_status_track
   import cyc_cmd_pkg::*;
#(
   parameter int WRITE_LAG = 1,
   localparam int CNT_W = $clog2(WRITE_LAG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status,
   input  logic              ready,
   input  logic              inbound_now,
   output logic [STAT_W-1:0] type_q,
   output logic              ale_q,
   output logic              dtr_q,
   output logic              phase_on,
   output logic              late_ok
);

   logic [STAT_W-1:0] prev_q;
   logic              busy_q;
   logic [CNT_W-1:0]  lag_cnt_q;
   logic              start_c;
   logic              finish_c;

   assign start_c  = !busy_q && (prev_q == ST_IDLE) && (status != ST_IDLE);
   assign finish_c = busy_q && (status == ST_IDLE) && ready;
   assign phase_on = busy_q && !finish_c;
   assign late_ok  = (lag_cnt_q >= CNT_W'(WRITE_LAG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= ST_IDLE;
      end else begin
         prev_q <= status;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ale_q     <= 1'b0;
         dtr_q     <= 1'b1;
         type_q    <= ST_IDLE;
         lag_cnt_q <= '0;
      end else if (start_c) begin
         busy_q    <= 1'b1;
         ale_q     <= 1'b1;
         dtr_q     <= !inbound_now;
         type_q    <= status;
         lag_cnt_q <= '0;
      end else if (finish_c) begin
         busy_q    <= 1'b0;
         ale_q     <= 1'b0;
         dtr_q     <= 1'b1;
         type_q    <= ST_IDLE;
         lag_cnt_q <= '0;
      end else begin
         ale_q <= 1'b0;
         if (busy_q && !late_ok) begin
            lag_cnt_q <= lag_cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cyc_strobe_gen.sv
module cyc_strobe_gen
   import cyc_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       phase_on,
   input  logic       late_ok,
   input  cyc_class_t cls,
   output cmd_set_t   early_q,
   output logic       mwr_late_q,
   output logic       iowr_late_q,
   output logic       den_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         early_q     <= '0;
         mwr_late_q  <= 1'b0;
         iowr_late_q <= 1'b0;
         den_q       <= 1'b0;
      end else if (phase_on) begin
         early_q     <= cls.cmd;
         mwr_late_q  <= cls.cmd.mwr && late_ok;
         iowr_late_q <= cls.cmd.iowr && late_ok;
         den_q       <= cls.moves_data;
      end else begin
         early_q     <= '0;
         mwr_late_q  <= 1'b0;
         iowr_late_q <= 1'b0;
         den_q       <= 1'b0;
      end
   end

endmodule

// File: rtl/cyc_cmd_decoder.sv
module cyc_cmd_decoder
   import cyc_cmd_pkg::*;
#(
   parameter int WRITE_LAG      = 1,
   parameter int CMD_ACTIVE_LOW = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] bus_status,
   input  logic              ready,
   output logic              ale,
   output logic              den,
   output logic              dt_r,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_wr_adv,
   output logic              io_rd,
   output logic              io_wr,
   output logic              io_wr_adv,
   output logic              int_ack
);

   generate
      if (WRITE_LAG < 1 || WRITE_LAG > 15) begin : g_bad_lag
         $error("cyc_cmd_decoder: WRITE_LAG must lie in 1..15");
      end
      if (CMD_ACTIVE_LOW != 0 && CMD_ACTIVE_LOW != 1) begin : g_bad_pol
         $error("cyc_cmd_decoder: CMD_ACTIVE_LOW must be 0 or 1");
      end
   endgenerate

   cyc_class_t        cls_now;
   cyc_class_t        cls_held;
   logic [STAT_W-1:0] type_q;
   logic              phase_on;
   logic              late_ok;
   cmd_set_t          early_q;
   logic              mwr_late_q;
   logic              iowr_late_q;
   logic [NCMD-1:0]   cmd_hi;
   logic [NCMD-1:0]   cmd_pins;

   cyc_cmd_map u_map_now (
      .code (bus_status),
      .cls  (cls_now)
   );

   cyc_cmd_map u_map_held (
      .code (type_q),
      .cls  (cls_held)
   );

   cyc_status_track #(
      .WRITE_LAG (WRITE_LAG)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .status      (bus_status),
      .ready       (ready),
      .inbound_now (cls_now.inbound),
      .type_q      (type_q),
      .ale_q       (ale),
      .dtr_q       (dt_r),
      .phase_on    (phase_on),
      .late_ok     (late_ok)
   );

   cyc_strobe_gen u_strobe (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_on    (phase_on),
      .late_ok     (late_ok),
      .cls         (cls_held),
      .early_q     (early_q),
      .mwr_late_q  (mwr_late_q),
      .iowr_late_q (iowr_late_q),
      .den_q       (den)
   );

   assign cmd_hi = {early_q.mrd, mwr_late_q, early_q.mwr,
                    early_q.iord, iowr_late_q, early_q.iowr, early_q.inta};

   generate
      if (CMD_ACTIVE_LOW != 0) begin : g_pol_low
         assign cmd_pins = ~cmd_hi;
      end else begin : g_pol_high
         assign cmd_pins = cmd_hi;
      end
   endgenerate

   assign {mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv, int_ack} = cmd_pins;

   logic unused_now;
   assign unused_now = ^{cls_now.cmd, cls_now.moves_data, cls_held.inbound};

endmodule

// File: rtl/cyc_cmd_checker.sv
module cyc_cmd_checker #(
   parameter int CMD_ACTIVE_LOW = 0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] bus_status,
   input logic       ready,
   input logic       ale,
   input logic       den,
   input logic       dt_r,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       mem_wr_adv,
   input logic       io_rd,
   input logic       io_wr,
   input logic       io_wr_adv,
   input logic       int_ack
);

   logic [6:0] raw;
   logic [6:0] hi;
   logic       n_mrd, n_mw, n_mwa, n_iord, n_iow, n_iowa, n_inta;
   logic       early_any;
   logic       any_cmd;

   assign raw = {mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv, int_ack};
   assign hi  = (CMD_ACTIVE_LOW != 0) ? ~raw : raw;
   assign {n_mrd, n_mw, n_mwa, n_iord, n_iow, n_iowa, n_inta} = hi;
   assign early_any = n_mrd | n_mwa | n_iord | n_iowa | n_inta;
   assign any_cmd   = |hi;

   assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   assert_ale_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (!any_cmd && !den));

   assert_cmd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({n_mrd, n_mwa, n_iord, n_iowa, n_inta}));

   assert_first_cmd_after_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_any) |-> $past(ale));

   assert_mwr_needs_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      n_mw |-> n_mwa);

   assert_iowr_needs_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      n_iow |-> n_iowa);

   assert_end_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cmd && bus_status == 3'b111 && ready) |=> (!any_cmd && !den));

   assert_dir_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (n_mrd | n_iord | n_inta) |-> !dt_r);

   assert_dir_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (n_mwa | n_iowa) |-> dt_r);

   assert_den_with_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      den |-> early_any);

endmodule

bind cyc_cmd_decoder cyc_cmd_checker #(
   .CMD_ACTIVE_LOW (CMD_ACTIVE_LOW)
) u_cyc_cmd_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_status (bus_status),
   .ready      (ready),
   .ale        (ale),
   .den        (den),
   .dt_r       (dt_r),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .mem_wr_adv (mem_wr_adv),
   .io_rd      (io_rd),
   .io_wr      (io_wr),
   .io_wr_adv  (io_wr_adv),
   .int_ack    (int_ack)
);

// File: tb/cyc_cmd_decoder_bench.sv
module cyc_cmd_decoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LAG        = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_status = 3'b111;
   logic       ready = 1'b1;

   logic [9:0] obs_h;
   logic [9:0] obs_l;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cyc_cmd_decoder #(.WRITE_LAG(LAG), .CMD_ACTIVE_LOW(0)) u_cyc_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .bus_status(bus_status), .ready(ready),
      .ale(obs_h[9]), .den(obs_h[8]), .dt_r(obs_h[7]),
      .mem_rd(obs_h[6]), .mem_wr(obs_h[5]), .mem_wr_adv(obs_h[4]),
      .io_rd(obs_h[3]), .io_wr(obs_h[2]), .io_wr_adv(obs_h[1]), .int_ack(obs_h[0])
   );

   cyc_cmd_decoder #(.WRITE_LAG(LAG), .CMD_ACTIVE_LOW(1)) u_cyc_cmd_decoder_inv (
      .clk(clk), .rst_n(rst_n), .bus_status(bus_status), .ready(ready),
      .ale(obs_l[9]), .den(obs_l[8]), .dt_r(obs_l[7]),
      .mem_rd(obs_l[6]), .mem_wr(obs_l[5]), .mem_wr_adv(obs_l[4]),
      .io_rd(obs_l[3]), .io_wr(obs_l[2]), .io_wr_adv(obs_l[1]), .int_ack(obs_l[0])
   );

   localparam logic [9:0] IDLE_V = 10'b001_0000000;

   // Expected output vector {ale,den,dt_r,mem_rd,mem_wr,mem_wr_adv,io_rd,io_wr,io_wr_adv,int_ack}
   // phase: 1 = ale clock, 2 = early commands, 3 = early plus normal writes
   function automatic logic [9:0] expect_vec(input logic [2:0] c, input int phase);
      logic mrd, mwa, iord, iowa, inta, d;
      mrd  = c[2] & ~c[1];
      mwa  = (c == 3'd6);
      iord = (c == 3'd1);
      iowa = (c == 3'd2);
      inta = (c == 3'd0);
      d    = (c != 3'd3);
      case (phase)
         1: return {1'b1, 1'b0, c[1], 7'b0};
         2: return {1'b0, d, c[1], mrd, 1'b0, mwa, iord, 1'b0, iowa, inta};
         3: return {1'b0, d, c[1], mrd, mwa, mwa, iord, iowa, iowa, inta};
         default: return IDLE_V;
      endcase
   endfunction

   task automatic chk(input string req, input logic [9:0] exp_v);
      logic [9:0] exp_l;
      exp_l = exp_v ^ 10'b000_1111111;
      n_checks++;
      if (obs_h !== exp_v) begin
         n_fail++;
         $display("FAIL %s high-polarity copy: got %b expected %b", req, obs_h, exp_v);
      end
      n_checks++;
      if (obs_l !== exp_l) begin
         n_fail++;
         $display("FAIL R11 (%s) low-polarity copy: got %b expected %b", req, obs_l, exp_l);
      end
   endtask

   task automatic tick_chk(input string req, input logic [9:0] exp_v);
      @(negedge clk);
      chk(req, exp_v);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", IDLE_V);
      rst_n = 1'b1;
      tick_chk("R1 after release", IDLE_V);

      // Full sweep of every non-idle code with a ready-low stall at the end
      for (int c = 0; c < 7; c++) begin
         logic [2:0] cc;
         cc = 3'(c);
         bus_status = cc;
         tick_chk("R2 ale pulse and R8 direction", expect_vec(cc, 1));
         tick_chk("R3 R4 R5 R10 early commands", expect_vec(cc, 2));
         tick_chk("R6 normal write still held back", expect_vec(cc, 2));
         tick_chk("R6 normal write after lag", expect_vec(cc, 3));
         bus_status = 3'b111;
         ready = 1'b0;
         tick_chk("R7 held while not ready", expect_vec(cc, 3));
         tick_chk("R7 still held while not ready", expect_vec(cc, 3));
         ready = 1'b1;
         tick_chk("R7 end of cycle", IDLE_V);
         tick_chk("R8 idle between cycles", IDLE_V);
      end

      // Status changes in the middle of a memory read cycle
      bus_status = 3'b101;
      tick_chk("R9 start of read", expect_vec(3'b101, 1));
      bus_status = 3'b110;
      tick_chk("R9 type kept after change", expect_vec(3'b101, 2));
      tick_chk("R9 no new ale", expect_vec(3'b101, 2));
      tick_chk("R9 no write after change", expect_vec(3'b101, 2));
      bus_status = 3'b111;
      tick_chk("R7 end after changed status", IDLE_V);

      // Cycle cut short on its second edge: no command at all
      bus_status = 3'b010;
      tick_chk("R2 ale of short cycle", expect_vec(3'b010, 1));
      bus_status = 3'b111;
      tick_chk("R7 short cycle has no command", IDLE_V);
      tick_chk("R7 short cycle stays idle", IDLE_V);

      // Back-to-back cycles: one idle sample is enough to restart
      bus_status = 3'b000;
      tick_chk("R2 restart ale", expect_vec(3'b000, 1));
      tick_chk("R3 interrupt acknowledge", expect_vec(3'b000, 2));
      bus_status = 3'b111;
      tick_chk("R7 end of acknowledge", IDLE_V);
      bus_status = 3'b001;
      tick_chk("R2 next cycle ale", expect_vec(3'b001, 1));
      tick_chk("R3 io read", expect_vec(3'b001, 2));
      bus_status = 3'b111;
      tick_chk("R7 end of io read", IDLE_V);

      // Reset in the middle of a write cycle
      bus_status = 3'b110;
      tick_chk("R2 write start", expect_vec(3'b110, 1));
      tick_chk("R6 write early", expect_vec(3'b110, 2));
      rst_n = 1'b0;
      #1;
      chk("R1 reset mid-cycle", IDLE_V);
      bus_status = 3'b111;
      @(negedge clk);
      rst_n = 1'b1;
      tick_chk("R1 idle after reset", IDLE_V);

      finish_run();
   end

endmodule